// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a virtual address into a physical one through a small table of segment descriptors belonging to the running process. The upper bits of the virtual address pick a descriptor, and the lower bits are an offset into that segment. Each descriptor holds a physical base, a limit (the largest legal offset) and a three-bit permission mask. On every load, store or instruction fetch, one lookup adds the base to the offset, compares the offset with the limit, and tests the access kind against the mask. The result is reported one clock later as a translation or as a fault with a cause.

Privileged logic owns a write port and a read port on the descriptor table. On a context switch, it saves the outgoing process's descriptors through the read port and loads the incoming ones through the write port. Each request is looked up combinationally. A small response state machine registers the outcome. After a request it goes to ST_GRANT when the access is legal and to ST_DENY when it is not. With no request it goes to ST_IDLE. These transitions are taken on every clock edge from any state.

Top module: `segx_xlate`

## Requirements
- R1: During and after reset, rsp_valid is low and every descriptor reads back as base 0, limit 0 and mask 000, where 000 denies every access.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and low otherwise.
- R3: The virtual address carries the segment number in its top SEG_BITS bits and the offset in its low OFF_BITS bits. For a legal access, rsp_pa is (base + offset) modulo 2^PA_BITS, rsp_fault is 0 and rsp_cause is 00.
- R4: An offset strictly greater than the descriptor limit gives rsp_fault 1, rsp_cause 01 and rsp_pa 0. An offset equal to the limit is legal.
- R5: The mask uses bit 0 for read, bit 1 for write and bit 2 for execute. Access code 00 (load) needs bit 0, 01 (store) needs bit 1 and 10 (fetch) needs bit 2. A missing bit gives rsp_fault 1, rsp_cause 10 and rsp_pa 0.
- R6: Access code 11 is never permitted and gives rsp_cause 10 when the offset is within the limit.
- R7: When an access breaks both the limit and the mask, rsp_cause is 01.
- R8: With tbl_we high at a clock edge, entry tbl_widx takes tbl_wbase, tbl_wsize and tbl_wperm. The read port returns entry tbl_ridx combinationally.
- R9: A request made in the same cycle as a table write is translated with the entry's old contents. The next request sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_va | input | SEG_BITS+OFF_BITS | Virtual address: segment number above the offset |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| tbl_we | input | 1 | Table write strobe |
| tbl_widx | input | SEG_BITS | Entry to write |
| tbl_wbase | input | PA_BITS | Base to write |
| tbl_wsize | input | OFF_BITS | Limit to write |
| tbl_wperm | input | 3 | Permission mask to write |
| tbl_ridx | input | SEG_BITS | Entry to read |
| tbl_rbase | output | PA_BITS | Base of the read entry |
| tbl_rsize | output | OFF_BITS | Limit of the read entry |
| tbl_rperm | output | 3 | Mask of the read entry |
| rsp_valid | output | 1 | Result present |
| rsp_pa | output | PA_BITS | Physical address, zero on a fault |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 00 none, 01 limit, 10 permission |

## Verification
The hardest case to reach is a request that lands in the same cycle as a write to the very entry it selects. The stimulus drives both in one cycle against an entry whose old limit is 0 and whose new contents would allow the access. It then expects a limit fault, and on the following request a clean translation. The limit-over-permission priority needs an entry with mask 000 and an offset past its limit. Physical wrap-around needs a base near the top of the physical space.

// File: rtl/segx_pkg.sv
package segx_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_BOUND = 2'b01,
        CAUSE_PERM  = 2'b10
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GRANT = 2'b01,
        ST_DENY  = 2'b10
    } rsp_state_e;

    localparam int PERM_W  = 3;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
endpackage

// File: rtl/segx_table.sv
module segx_table
    import segx_pkg::*;
#(
    parameter int SEG_BITS = 3,
    parameter int OFF_BITS = 12,
    parameter int PA_BITS  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [SEG_BITS-1:0] widx,
    input  logic [PA_BITS-1:0]  wbase,
    input  logic [OFF_BITS-1:0] wsize,
    input  logic [PERM_W-1:0]   wperm,
    input  logic [SEG_BITS-1:0] lidx,
    output logic [PA_BITS-1:0]  lbase,
    output logic [OFF_BITS-1:0] lsize,
    output logic [PERM_W-1:0]   lperm,
    input  logic [SEG_BITS-1:0] ridx,
    output logic [PA_BITS-1:0]  rbase,
    output logic [OFF_BITS-1:0] rsize,
    output logic [PERM_W-1:0]   rperm
);
    localparam int ENTRIES = 1 << SEG_BITS;

    logic [PA_BITS-1:0]  base_q [ENTRIES];
    logic [OFF_BITS-1:0] size_q [ENTRIES];
    logic [PERM_W-1:0]   perm_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [SEG_BITS-1:0] IDX = SEG_BITS'(e);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[e] <= '0;
                size_q[e] <= '0;
                perm_q[e] <= '0;
            end else if (we && widx == IDX) begin
                base_q[e] <= wbase;
                size_q[e] <= wsize;
                perm_q[e] <= wperm;
            end
        end
    end

    always_comb begin
        lbase = base_q[lidx];
        lsize = size_q[lidx];
        lperm = perm_q[lidx];
        rbase = base_q[ridx];
        rsize = size_q[ridx];
        rperm = perm_q[ridx];
    end

    // R8
    tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (base_q[$past(widx)] == $past(wbase)) && (size_q[$past(widx)] == $past(wsize))
               && (perm_q[$past(widx)] == $past(wperm)));
endmodule

// File: rtl/segx_check.sv
module segx_check
    import segx_pkg::*;
#(
    parameter int OFF_BITS = 12,
    parameter int PA_BITS  = 16
) (
    input  logic [OFF_BITS-1:0] off,
    input  logic [1:0]          acc,
    input  logic [PA_BITS-1:0]  base,
    input  logic [OFF_BITS-1:0] size,
    input  logic [PERM_W-1:0]   perm,
    output logic [PA_BITS-1:0]  pa,
    output cause_e              cause
);
    logic allow;

    always_comb begin
        pa = base + PA_BITS'(off);
        unique case (acc_e'(acc))
            ACC_LOAD:  allow = perm[PERM_RD];
            ACC_STORE: allow = perm[PERM_WR];
            ACC_FETCH: allow = perm[PERM_EX];
            default:   allow = 1'b0;
        endcase
        if (off > size)  cause = CAUSE_BOUND;
        else if (!allow) cause = CAUSE_PERM;
        else             cause = CAUSE_NONE;
    end
endmodule

// File: rtl/segx_xlate.sv
module segx_xlate
    import segx_pkg::*;
#(
    parameter int SEG_BITS = 3,
    parameter int OFF_BITS = 12,
    parameter int PA_BITS  = 16,
    localparam int VA_BITS = SEG_BITS + OFF_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [VA_BITS-1:0]  req_va,
    input  logic [1:0]          req_acc,
    input  logic                tbl_we,
    input  logic [SEG_BITS-1:0] tbl_widx,
    input  logic [PA_BITS-1:0]  tbl_wbase,
    input  logic [OFF_BITS-1:0] tbl_wsize,
    input  logic [2:0]          tbl_wperm,
    input  logic [SEG_BITS-1:0] tbl_ridx,
    output logic [PA_BITS-1:0]  tbl_rbase,
    output logic [OFF_BITS-1:0] tbl_rsize,
    output logic [2:0]          tbl_rperm,
    output logic                rsp_valid,
    output logic [PA_BITS-1:0]  rsp_pa,
    output logic                rsp_fault,
    output logic [1:0]          rsp_cause
);
    logic [SEG_BITS-1:0] seg;
    logic [OFF_BITS-1:0] off;
    logic [PA_BITS-1:0]  ent_base;
    logic [OFF_BITS-1:0] ent_size;
    logic [PERM_W-1:0]   ent_perm;
    logic [PA_BITS-1:0]  calc_pa;
    cause_e              calc_cause;

    rsp_state_e          state_q, state_d;
    logic [PA_BITS-1:0]  pa_q;
    cause_e              cause_q;

    assign seg = req_va[VA_BITS-1:OFF_BITS];
    assign off = req_va[OFF_BITS-1:0];

    segx_table #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .widx(tbl_widx), .wbase(tbl_wbase), .wsize(tbl_wsize), .wperm(tbl_wperm),
        .lidx(seg), .lbase(ent_base), .lsize(ent_size), .lperm(ent_perm),
        .ridx(tbl_ridx), .rbase(tbl_rbase), .rsize(tbl_rsize), .rperm(tbl_rperm)
    );

    segx_check #(.OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_check (
        .off(off), .acc(req_acc), .base(ent_base), .size(ent_size), .perm(ent_perm),
        .pa(calc_pa), .cause(calc_cause)
    );

    always_comb begin
        if (!req_valid)                    state_d = ST_IDLE;
        else if (calc_cause != CAUSE_NONE) state_d = ST_DENY;
        else                               state_d = ST_GRANT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pa_q    <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            pa_q    <= (state_d == ST_GRANT) ? calc_pa : '0;
            cause_q <= req_valid ? calc_cause : CAUSE_NONE;
        end
    end

    always_comb begin
        rsp_pa    = pa_q;
        rsp_cause = cause_q;
        unique case (state_q)
            ST_GRANT: begin rsp_valid = 1'b1; rsp_fault = 1'b0; end
            ST_DENY:  begin rsp_valid = 1'b1; rsp_fault = 1'b1; end
            default:  begin rsp_valid = 1'b0; rsp_fault = 1'b0; end
        endcase
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));

    // R3
    ok_cause_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_cause == CAUSE_NONE);

    // R4
    fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_pa == '0) && (rsp_cause != CAUSE_NONE));

    // R7
    bound_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && off > ent_size) |=> rsp_fault && rsp_cause == CAUSE_BOUND);

    // R6
    rsvd_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == 2'b11) |=> rsp_fault);
endmodule

// File: tb/segx_xlate_tb.sv
module segx_xlate_tb;
    localparam int SEG_BITS = 3;
    localparam int OFF_BITS = 12;
    localparam int PA_BITS  = 16;
    localparam int VA_BITS  = SEG_BITS + OFF_BITS;
    localparam int ENTRIES  = 1 << SEG_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_BITS-1:0] req_va = '0;
    logic [1:0] req_acc = '0;
    logic tbl_we = 1'b0;
    logic [SEG_BITS-1:0] tbl_widx = '0;
    logic [PA_BITS-1:0] tbl_wbase = '0;
    logic [OFF_BITS-1:0] tbl_wsize = '0;
    logic [2:0] tbl_wperm = '0;
    logic [SEG_BITS-1:0] tbl_ridx = '0;
    logic [PA_BITS-1:0] tbl_rbase;
    logic [OFF_BITS-1:0] tbl_rsize;
    logic [2:0] tbl_rperm;
    logic rsp_valid;
    logic [PA_BITS-1:0] rsp_pa;
    logic rsp_fault;
    logic [1:0] rsp_cause;

    always #2 clk = ~clk;

    segx_xlate #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
        .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wbase(tbl_wbase), .tbl_wsize(tbl_wsize),
        .tbl_wperm(tbl_wperm), .tbl_ridx(tbl_ridx), .tbl_rbase(tbl_rbase), .tbl_rsize(tbl_rsize),
        .tbl_rperm(tbl_rperm), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause)
    );

    typedef struct {
        logic [PA_BITS-1:0] pa;
        logic               fault;
        logic [1:0]         cause;
        string              tag;
    } exp_t;

    exp_t sbq[$];
    logic [PA_BITS-1:0]  sh_base [ENTRIES];
    logic [OFF_BITS-1:0] sh_size [ENTRIES];
    logic [2:0]          sh_perm [ENTRIES];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input int seg, input int off, input int acc, input string tag);
        exp_t r;
        logic ok;
        logic [PA_BITS:0] sum;
        case (acc)
            0: ok = sh_perm[seg][0];
            1: ok = sh_perm[seg][1];
            2: ok = sh_perm[seg][2];
            default: ok = 1'b0;
        endcase
        sum = {1'b0, sh_base[seg]} + (PA_BITS+1)'(off);
        r.tag = tag;
        if (off > int'(sh_size[seg])) begin r.fault = 1; r.cause = 2'b01; r.pa = '0; end
        else if (!ok) begin r.fault = 1; r.cause = 2'b10; r.pa = '0; end
        else begin r.fault = 0; r.cause = 2'b00; r.pa = sum[PA_BITS-1:0]; end
        return r;
    endfunction

    task automatic send(input int seg, input int off, input int acc, input string tag);
        @(negedge clk);
        tbl_we = 1'b0;
        req_valid = 1'b1;
        req_va = {SEG_BITS'(seg), OFF_BITS'(off)};
        req_acc = 2'(acc);
        sbq.push_back(model(seg, off, acc, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            tbl_we = 1'b0;
        end
    endtask

    task automatic wr(input int idx, input int base, input int size, input int perm);
        @(negedge clk);
        req_valid = 1'b0;
        tbl_we = 1'b1;
        tbl_widx = SEG_BITS'(idx);
        tbl_wbase = PA_BITS'(base);
        tbl_wsize = OFF_BITS'(size);
        tbl_wperm = 3'(perm);
        @(negedge clk);
        tbl_we = 1'b0;
        sh_base[idx] = PA_BITS'(base);
        sh_size[idx] = OFF_BITS'(size);
        sh_perm[idx] = 3'(perm);
    endtask

    // R9: write and request to the same entry in one cycle
    task automatic wr_with_req(input int idx, input int base, input int size, input int perm,
                               input int off, input int acc);
        @(negedge clk);
        tbl_we = 1'b1;
        tbl_widx = SEG_BITS'(idx);
        tbl_wbase = PA_BITS'(base);
        tbl_wsize = OFF_BITS'(size);
        tbl_wperm = 3'(perm);
        req_valid = 1'b1;
        req_va = {SEG_BITS'(idx), OFF_BITS'(off)};
        req_acc = 2'(acc);
        sbq.push_back(model(idx, off, acc, "R9 same-cycle old entry"));
        @(negedge clk);
        tbl_we = 1'b0;
        req_valid = 1'b0;
        sh_base[idx] = PA_BITS'(base);
        sh_size[idx] = OFF_BITS'(size);
        sh_perm[idx] = 3'(perm);
    endtask

    task automatic readback(input int idx, input string tag);
        @(negedge clk);
        tbl_ridx = SEG_BITS'(idx);
        #1;
        chk(tag, "rbase", 32'(tbl_rbase), 32'(sh_base[idx]));
        chk(tag, "rsize", 32'(tbl_rsize), 32'(sh_size[idx]));
        chk(tag, "rperm", 32'(tbl_rperm), 32'(sh_perm[idx]));
    endtask

    // Monitor: pops the scoreboard one cycle after each request
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2", "rsp_valid", 32'(rsp_valid), 32'(sbq.size() != 0));
            if (rsp_valid && sbq.size() != 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "rsp_pa", 32'(rsp_pa), 32'(e.pa));
                chk(e.tag, "rsp_fault", 32'(rsp_fault), 32'(e.fault));
                chk(e.tag, "rsp_cause", 32'(rsp_cause), 32'(e.cause));
            end else if (sbq.size() != 0) begin
                void'(sbq.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            sh_base[i] = '0; sh_size[i] = '0; sh_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_ridx = SEG_BITS'(i);
            #1;
            chk("R1", "reset entry", {13'd0, tbl_rperm, tbl_rsize, tbl_rbase[3:0]} |
                32'(tbl_rbase), 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        wr(0, 16'h1000, 12'h0FF, 3'b011);
        wr(1, 16'hF800, 12'hFFF, 3'b100);
        wr(2, 16'h0040, 12'h000, 3'b001);
        wr(3, 16'h2000, 12'h0FF, 3'b000);
        wr(7, 16'h1234, 12'h800, 3'b111);
        readback(0, "R8 entry0");
        readback(1, "R8 entry1");
        readback(7, "R8 entry7");

        send(0, 12'h010, 0, "R3 load ok");
        send(0, 12'h0FF, 1, "R4 offset equals limit");
        send(0, 12'h100, 0, "R4 offset past limit");
        send(0, 12'h020, 2, "R5 fetch without X");
        send(1, 12'hFFF, 2, "R3 wrap fetch");
        send(1, 12'h000, 0, "R5 load without R");
        send(2, 12'h000, 0, "R4 zero limit ok");
        send(2, 12'h001, 0, "R4 zero limit past");
        send(3, 12'h000, 0, "R5 mask none");
        send(3, 12'h100, 1, "R7 both violations");
        send(7, 12'h800, 3, "R6 reserved access");
        send(7, 12'h7FF, 2, "R3 fetch ok");
        send(7, 12'h123, 1, "R3 store ok");
        idle(3);

        wr_with_req(4, 16'h3000, 12'h010, 3'b001, 12'h005, 0);
        send(4, 12'h005, 0, "R9 next request new entry");
        idle(3);
        readback(4, "R8 entry4");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule